// File: doc/BRIEF.md
# Integrating Input Level Detector

The block estimates the strength of a signed 14-bit sample stream. On every clock it takes the magnitude of the current sample and compares it with a programmable threshold. It then adds the gated magnitude into an accumulator over an interval whose length in clock cycles is programmable. When the interval counter runs out, the top 23 bits of the accumulator are copied into a holding register. A ready flag tells a slower processor that a fresh value is waiting. The processor reads the result one byte at a time through a small addressed read port.

The interval has two run modes. In repeating mode the counter reloads and a new result is captured at the end of every interval. In one-shot mode the block halts after a single interval and keeps its result. Software starts or restarts an interval at any time with a start strobe. An external sync pulse can do the same when sync is enabled. A restart clears the accumulator and never captures the partial sum. Only the natural end of an interval updates the holding register.

Top module: `input_level_detector`

## Requirements
- R1: Each sample is taken as a two's complement 14-bit value, so -8192 has magnitude 8192. Its magnitude is added to the sum only if the magnitude is at or above `threshold` (unsigned). Otherwise the sample adds zero.
- R2: A start request is a `startWr` pulse, or a `syncIn` pulse while `syncEn` is 1. It loads the counter from `interval` and clears the accumulator. The samples present at the N rising edges that follow (N = `interval`) form the interval. A start with `interval` = 0 leaves the block idle.
- R3: At the last edge of an interval, result bits 22:0 take bits 29:7 of the 30-bit sum over that interval. A start request arriving before or at that edge discards the partial sum and captures nothing.
- R4: When `contMode` is 1 and an interval ends, the counter reloads from the current `interval` with a cleared accumulator, so results are captured back to back. If `interval` is 0 at that moment, the block stops instead.
- R5: When `contMode` is 0, the block halts after one interval. The result then stays unchanged until a later interval ends.
- R6: Each capture sets `ready`. The status byte at address 3 holds `ready` in bit 0 and `overrun` in bit 1, with its other bits zero.
- R7: A `rdStrobe` at address 2, the most significant result byte, clears `ready` and `overrun`. If a capture happens on the same edge, the capture sets `ready` again and `overrun` stays clear.
- R8: A capture while `ready` is still set, and not cleared on that edge, overwrites the result and sets `overrun`.
- R9: While `syncEn` is 0, `syncIn` has no effect on the counter, the accumulator or the result.
- R10: `rdData` is a combinational view of the stored state. Address 0 gives result bits 7:0 and address 1 gives bits 15:8. Address 2 gives {0, bits 22:16}. Address 3 gives the status byte. Addresses 4 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 14 | Signed input sample |
| threshold | input | 14 | Unsigned magnitude gate level |
| interval | input | 16 | Interval length in cycles |
| startWr | input | 1 | Software start/restart strobe |
| contMode | input | 1 | 1 = repeating, 0 = one-shot |
| syncEn | input | 1 | Lets syncIn start an interval |
| syncIn | input | 1 | External sync pulse |
| rdAddr | input | 3 | Read byte select |
| rdStrobe | input | 1 | Read access marker (clears flags at address 2) |
| rdData | output | 8 | Selected byte |
| ready | output | 1 | Fresh result waiting |
| overrun | output | 1 | A result was overwritten before being read |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `interval` is meaningful whenever a start or a repeating reload samples it. They also assume that a read strobe marks a single access. The stimulus drives every input at the falling edge, so each value is stable across the rising edge that uses it. Random intervals are kept short, between 1 and 40 cycles, so that many captures, restarts, sync pulses and overruns happen inside one run. Directed cases cover the extreme sample -8192, an interval of zero, and restarts at or just before the last edge.

// File: rtl/lvl_det_pkg.sv
package lvl_det_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic clrAcc;  // zero the accumulator at this edge
    logic accEn;   // add the gated magnitude at this edge
    logic latch;   // copy the completed sum to the holding register
  } detStrobe_t;
endpackage

// File: rtl/lvl_det_ctrl.sv
module lvl_det_ctrl
  import lvl_det_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] interval,
  input  logic             startWr,
  input  logic             contMode,
  input  logic             syncEn,
  input  logic             syncIn,
  output detStrobe_t       strobe
);
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             startReq;
  logic             lastCyc;

  assign startReq = startWr | (syncEn & syncIn);
  assign lastCyc  = running && (cnt == CNT_W'(1));

  always_comb begin
    strobe.clrAcc = startReq | lastCyc;
    strobe.accEn  = running & ~startReq;
    strobe.latch  = lastCyc & ~startReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (startReq) begin
      cnt     <= interval;
      running <= (interval != '0);
    end else if (lastCyc) begin
      if (contMode && interval != '0) begin
        cnt <= interval;
      end else begin
        cnt     <= '0;
        running <= 1'b0;
      end
    end else if (running) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R2: a start request with a nonzero interval arms the counter with that interval
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && interval != '0) |=> (running && cnt == $past(interval)));

  // R4: in repeating mode a capture reloads the counter
  assert_cont_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && contMode && interval != '0) |=> (running && cnt == $past(interval)));

  // R5: in one-shot mode a capture halts the counter
  assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && !contMode) |=> !running);

  // R9: a sync pulse while sync is disabled only lets the count proceed
  assert_sync_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn && syncIn && !startWr && running && cnt > CNT_W'(1))
      |=> (running && cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/lvl_det_datapath.sv
module lvl_det_datapath
  import lvl_det_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int ACC_W    = 30,
  parameter int RES_W    = 23,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  detStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdStrobe,
  output logic [7:0]          rdData,
  output logic                ready,
  output logic                overrun
);
  localparam int RES_BYTES = (RES_W + 7) / 8;
  localparam int PAD_W     = RES_BYTES * 8;
  localparam int MSB_ADDR  = RES_BYTES - 1;
  localparam int STAT_ADDR = RES_BYTES;

  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] gated;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    sum;
  logic [RES_W-1:0]    hold;
  logic [PAD_W-1:0]    holdPad;
  logic                msbRead;

  // magnitude: unsigned reinterpretation makes -min come out right
  assign mag     = sampleIn[SAMPLE_W-1] ? (~sampleIn + SAMPLE_W'(1)) : sampleIn;
  assign gated   = (mag >= threshold) ? mag : '0;
  assign sum     = acc + ACC_W'(gated);
  assign holdPad = PAD_W'(hold);
  assign msbRead = rdStrobe && (rdAddr == ADDR_W'(MSB_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.clrAcc) begin
      acc <= '0;
    end else if (strobe.accEn) begin
      acc <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold    <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else if (strobe.latch) begin
      hold    <= sum[ACC_W-1 -: RES_W];
      ready   <= 1'b1;
      overrun <= msbRead ? 1'b0 : (overrun | ready);
    end else if (msbRead) begin
      ready   <= 1'b0;
      overrun <= 1'b0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int b = 0; b < RES_BYTES; b++) begin
      if (rdAddr == ADDR_W'(b)) rdData = holdPad[b*8 +: 8];
    end
    if (rdAddr == ADDR_W'(STAT_ADDR)) rdData = {6'b0, overrun, ready};
  end

  // R6: every capture raises ready
  assert_ready_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> ready);

  // R7: reading the top byte without a capture clears both flags
  assert_msb_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msbRead && !strobe.latch) |=> (!ready && !overrun));

  // R8: a capture on top of an unread result flags overrun
  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && ready && !msbRead) |=> overrun);

  // R3 R5: the result changes only on a capture
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(hold));
endmodule

// File: rtl/input_level_detector.sv
module input_level_detector
  import lvl_det_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 16,
  parameter int RES_W    = 23,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [CNT_W-1:0]    interval,
  input  logic                startWr,
  input  logic                contMode,
  input  logic                syncEn,
  input  logic                syncIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdStrobe,
  output logic [7:0]          rdData,
  output logic                ready,
  output logic                overrun
);
  // wide enough for a full-length interval of full-scale magnitudes
  localparam int ACC_W = CNT_W + SAMPLE_W;

  detStrobe_t strobe;

  lvl_det_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .interval (interval),
    .startWr  (startWr),
    .contMode (contMode),
    .syncEn   (syncEn),
    .syncIn   (syncIn),
    .strobe   (strobe)
  );

  lvl_det_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .RES_W    (RES_W),
    .ADDR_W   (ADDR_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleIn  (sampleIn),
    .threshold (threshold),
    .rdAddr    (rdAddr),
    .rdStrobe  (rdStrobe),
    .rdData    (rdData),
    .ready     (ready),
    .overrun   (overrun)
  );
endmodule

// File: tb/tb_input_level_detector.sv
module tb_input_level_detector;
  localparam time HALF = 2.5ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic [13:0] sampleIn;
  logic [13:0] threshold;
  logic [15:0] interval;
  logic        startWr, contMode, syncEn, syncIn, rdStrobe;
  logic [2:0]  rdAddr;
  logic [7:0]  rdData;
  logic        ready, overrun;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit          mRun;
  int          mCnt;
  longint      mAcc;
  int          mHold;
  bit          mReady, mOvr;

  always #HALF clk = ~clk;

  input_level_detector dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .threshold(threshold),
    .interval(interval), .startWr(startWr), .contMode(contMode),
    .syncEn(syncEn), .syncIn(syncIn), .rdAddr(rdAddr), .rdStrobe(rdStrobe),
    .rdData(rdData), .ready(ready), .overrun(overrun)
  );

  function automatic int gatedMag(logic [13:0] s, logic [13:0] thr);
    int v = int'($signed(s));
    int m = (v < 0) ? -v : v;
    return (m >= int'(thr)) ? m : 0;
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return mHold[7:0];
      3'd1: return mHold[15:8];
      3'd2: return {1'b0, mHold[22:16]};
      3'd3: return {6'b0, mOvr, mReady};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // model update for one rising edge, using the values driven before it
  task automatic modelEdge();
    bit start = startWr || (syncEn && syncIn);
    bit clr   = rdStrobe && rdAddr == 3'd2;
    bit latch = !start && mRun && mCnt == 1;
    longint sum = mAcc + gatedMag(sampleIn, threshold);
    if (start) begin
      mRun = (interval != 0); mCnt = int'(interval); mAcc = 0;
    end else if (mRun) begin
      if (mCnt == 1) begin
        mHold = int'((sum >> 7) & 64'h7FFFFF);
        mAcc  = 0;
        if (contMode && interval != 0) mCnt = int'(interval);
        else begin mRun = 0; mCnt = 0; end
      end else begin
        mAcc = sum; mCnt--;
      end
    end
    if (latch) begin
      mOvr   = clr ? 1'b0 : (mOvr | mReady);
      mReady = 1'b1;
    end else if (clr) begin
      mReady = 0; mOvr = 0;
    end
  endtask

  // one clock: inputs already set at negedge; check just after the edge
  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    #1;
    check(tag, "ready", int'(ready), int'(mReady));
    check(tag, "overrun", int'(overrun), int'(mOvr));
    check(tag, "rdData", int'(rdData), int'(expRead(rdAddr)));
    @(negedge clk);
    startWr = 0; syncIn = 0; rdStrobe = 0;
  endtask

  task automatic runSamples(string tag, int n, int val);
    for (int i = 0; i < n; i++) begin
      sampleIn = 14'(val);
      step(tag);
    end
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 8; a++) begin
      rdAddr = 3'(a);
      #1;
      check(tag, "readmap", int'(rdData), int'(expRead(3'(a))));
    end
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; sampleIn = 0; threshold = 0; interval = 0; startWr = 0;
    contMode = 0; syncEn = 0; syncIn = 0; rdAddr = 3; rdStrobe = 0;
    mRun = 0; mCnt = 0; mAcc = 0; mHold = 0; mReady = 0; mOvr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R6", "reset status", int'(rdData), 0);
    check("R6", "reset ready", int'(ready), 0);

    // R1 R2 R3 R5: one-shot, full-scale negative sample included
    interval = 16'd64; startWr = 1; sampleIn = 14'h2000;
    step("R2");
    runSamples("R1", 64, -8192);
    check("R3", "capture value", mHold, 4096);
    readAll("R10");
    runSamples("R5", 10, 5000);

    // R7: read top byte clears ready
    rdAddr = 2; rdStrobe = 1; step("R7");
    check("R7", "ready cleared", int'(ready), 0);

    // R1: threshold gating below and at level
    threshold = 14'd3000; interval = 16'd200; startWr = 1; step("R1");
    for (int i = 0; i < 200; i++) begin
      sampleIn = (i % 2 == 0) ? 14'd2999 : 14'(-3000);
      rdAddr = 3'(i % 4);
      step("R1");
    end
    check("R1", "gated sum", mHold, (100 * 3000) >> 7);

    // R3: restart before end discards, also restart at last edge
    threshold = 0; interval = 16'd30; startWr = 1; step("R3");
    runSamples("R3", 20, 7000);
    startWr = 1; step("R3");
    runSamples("R3", 29, 100);
    startWr = 1; sampleIn = 14'd8000; step("R3");
    runSamples("R3", 30, 1000);

    // R2: zero interval leaves block idle
    interval = 0; startWr = 1; step("R2");
    runSamples("R2", 20, 8000);
    readAll("R2");

    // R9: sync disabled ignored, enabled restarts
    interval = 16'd12; startWr = 1; step("R9");
    for (int i = 0; i < 12; i++) begin
      syncIn = (i == 5); sampleIn = 14'd6000; step("R9");
    end
    syncEn = 1; interval = 16'd10; syncIn = 1; step("R9");
    runSamples("R9", 12, 4000);
    syncEn = 0;

    // R4 R8: repeating mode with no reads produces overrun
    contMode = 1; interval = 16'd8; startWr = 1; step("R4");
    runSamples("R8", 30, -1234);
    rdAddr = 3; #1; check("R8", "overrun set", int'(overrun), 1);
    // R7: read on a capture edge keeps ready, clears overrun
    for (int i = 0; i < 8; i++) begin
      rdAddr = 2; rdStrobe = (mCnt == 1); step("R7");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      sampleIn  = 14'($urandom);
      threshold = 14'($urandom_range(0, 4000));
      rdAddr    = 3'($urandom);
      rdStrobe  = ($urandom_range(0, 9) == 0);
      contMode  = ($urandom_range(0, 3) != 0);
      syncEn    = $urandom_range(0, 1);
      syncIn    = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 60) == 0) begin
        interval = 16'($urandom_range(0, 40)); startWr = 1;
      end else if ($urandom_range(0, 40) == 0) begin
        interval = 16'($urandom_range(1, 40));
      end
      step("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule